// File: doc/BRIEF.md
# Step Attenuator Control Word Interface

This block produces the 6-bit control word for a digital step attenuator whose least significant step is 0.5 dB. The full range runs from 0 dB to 31.5 dB. The word can be loaded in two ways. The first is a three-wire serial port made of a data line, a shift clock and a load enable. The second is six parallel pins. A mode pin chooses between the two sources. The load enable gates a single output latch that both sources share. When the enable is high, the latch is transparent. When it is low, the latch holds its value. In parallel mode, holding the enable high gives direct control from the pins. Pulsing the enable gives latched control.

Everything runs in one system clock domain. That clock must be at least four times faster than the serial clock. The serial clock, data, enable, mode and parallel pins each pass through a two-stage synchroniser. Serial clock edges are found by comparing the synchronised level with its value one cycle earlier. While reset is asserted, the reset word is reloaded on every cycle. In serial mode the reset word is the live parallel pin value. In parallel mode it is a preset chosen by a 2-bit code. Along with the raw word, the block outputs the attenuation in half-dB units.

Top module: `atten_ctrl`

## Requirements
- R1: `half_db_o` equals the weighted sum of the word bits in half-dB units. Bit 0 weighs 1 (0.5 dB), bit 1 weighs 2, bit 2 weighs 4, bit 3 weighs 8, bit 4 weighs 16 (8 dB) and bit 5 weighs 32 (16 dB).
- R2: `mode_ser_i` high selects serial mode and low selects parallel mode. The source that is not selected has no effect on `word_o`.
- R3: In parallel mode with `le_i` held high, `word_o` equals `par_word_i` no later than the third system clock edge after the pins change.
- R4: While `le_i` is low, `word_o` holds its value. When `le_i` is pulsed high and then low, the latch keeps the pin value (parallel mode) or the register value (serial mode) that was present while the enable was high.
- R5: In serial mode, each rising edge of `ser_clk_i` shifts `ser_data_i` into a 6-bit register, most significant (16 dB) bit first. Six edges with `le_i` low leave `word_o` unchanged. A following pulse on `le_i` loads all six bits.
- R6: Shifting continues while `le_i` is high, and `word_o` tracks the register after each edge.
- R7: While reset is asserted in serial mode, `word_o` takes the value on `par_word_i`.
- R8: While reset is asserted in parallel mode, `word_o` takes the preset selected by `preset_i`: 00 gives 0, 01 gives 16 (8 dB), 10 gives 32 (16 dB) and 11 gives 63 (31.5 dB).
- R9: Serial transfers are captured correctly when `ser_clk_i` is high and low for as little as two system clock cycles each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock edge |
| mode_ser_i | input | 1 | 1 = serial source, 0 = parallel source |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| le_i | input | 1 | Load enable, latch transparent while high |
| par_word_i | input | 6 | Parallel word; also the reset word in serial mode |
| preset_i | input | 2 | Preset code for reset in parallel mode |
| word_o | output | 6 | Registered attenuator control word |
| half_db_o | output | 6 | Attenuation in 0.5 dB units |

## Verification
A shift register that has lost a bit, or that has taken a bit out of order, does not show up on `word_o` while the enable is low. It becomes visible a few cycles after the next enable pulse. The bench therefore checks the output both before and after each load pulse. A latch that leaks, or a mode that is decoded wrongly, changes `word_o` within three system cycles of the disturbing input. The bench waits past that window before it checks that the output has held. A bad reset value shows on the first cycle after reset, so every reset is followed by a check.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int WORD_W = 6;
  typedef logic [WORD_W-1:0] word_t;

  // preset code to control word (in half-dB units)
  function automatic word_t preset_word(input logic [1:0] code);
    case (code)
      2'b00:   preset_word = word_t'(0);
      2'b01:   preset_word = word_t'(16);
      2'b10:   preset_word = word_t'(32);
      default: preset_word = word_t'(63);
    endcase
  endfunction

  // weighted sum of bits; bit i weighs 2**i half-dB steps
  function automatic word_t half_db(input word_t w);
    word_t acc;
    acc = '0;
    for (int i = 0; i < WORD_W; i++)
      if (w[i]) acc = acc + word_t'(1 << i);
    half_db = acc;
  endfunction
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o
);
  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{raw_i[b]}};
        else        chain <= {chain[STAGES-2:0], raw_i[b]};
      end
      assign sync_o[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/atten_shift.sv
module atten_shift
  import atten_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t init_i,
  input  logic  shift_en_i,
  input  logic  bit_i,
  output word_t q_o
);
  word_t q;

  always_ff @(posedge clk) begin
    if (!rst_n)          q <= init_i;
    else if (shift_en_i) q <= {q[WORD_W-2:0], bit_i};
  end

  assign q_o = q;

  // R5: one detected edge moves every bit up one place and takes the new bit
  assert_shift_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en_i |=> q == {$past(q[WORD_W-2:0]), $past(bit_i)});

  // R5: the register is still without an edge
  assert_shift_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en_i |=> $stable(q));
endmodule

// File: rtl/atten_latch.sv
module atten_latch
  import atten_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t init_i,
  input  logic  open_i,
  input  logic  mode_ser_i,
  input  word_t ser_word_i,
  input  word_t par_word_i,
  output word_t word_o
);
  word_t word_q;
  word_t src;

  assign src = mode_ser_i ? ser_word_i : par_word_i;

  always_ff @(posedge clk) begin
    if (!rst_n)      word_q <= init_i;
    else if (open_i) word_q <= src;
  end

  assign word_o = word_q;

  // R4: a closed latch keeps its word
  assert_hold_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !open_i |=> $stable(word_q));

  // R3: an open latch in parallel mode copies the synchronised pins
  assert_par_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (open_i && !mode_ser_i) |=> word_q == $past(par_word_i));

  // R6: an open latch in serial mode copies the shift register
  assert_ser_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (open_i && mode_ser_i) |=> word_q == $past(ser_word_i));
endmodule

// File: rtl/atten_ctrl.sv
module atten_ctrl
  import atten_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_ser_i,
  input  logic       ser_data_i,
  input  logic       ser_clk_i,
  input  logic       le_i,
  input  logic [5:0] par_word_i,
  input  logic [1:0] preset_i,
  output logic [5:0] word_o,
  output logic [5:0] half_db_o
);
  localparam int BUS_W = WORD_W + 4;

  logic [BUS_W-1:0] raw_bus, sync_bus;
  logic  mode_s, le_s, sclk_s, sdata_s, sclk_prev;
  word_t par_s, init_word, shift_q, word_q;
  logic  sclk_rise;

  assign raw_bus = {mode_ser_i, le_i, ser_clk_i, ser_data_i, par_word_i};

  atten_sync #(.W(BUS_W), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (raw_bus),
    .sync_o (sync_bus)
  );

  assign {mode_s, le_s, sclk_s, sdata_s, par_s} = sync_bus;

  // reset word taken from the raw pins while reset is held
  assign init_word = mode_ser_i ? word_t'(par_word_i) : preset_word(preset_i);

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_prev <= ser_clk_i;
    else        sclk_prev <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_prev;

  atten_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (init_word),
    .shift_en_i (sclk_rise),
    .bit_i      (sdata_s),
    .q_o        (shift_q)
  );

  atten_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (init_word),
    .open_i     (le_s),
    .mode_ser_i (mode_s),
    .ser_word_i (shift_q),
    .par_word_i (par_s),
    .word_o     (word_q)
  );

  assign word_o    = word_q;
  assign half_db_o = half_db(word_q);

  // R9: an edge is reported for one cycle only
  assert_edge_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !sclk_rise);

  // R1: the all-zero word reads as zero attenuation
  assert_zero_db_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (word_o == '0) |-> (half_db_o == '0));
endmodule

// File: tb/tb_atten_ctrl.sv
module tb_atten_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_ser_i = 1'b0;
  logic       ser_data_i = 1'b0;
  logic       ser_clk_i = 1'b0;
  logic       le_i = 1'b0;
  logic [5:0] par_word_i = '0;
  logic [1:0] preset_i = '0;
  logic [5:0] word_o, half_db_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [5:0] sh;

  always #2 clk = ~clk;

  atten_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode_ser_i(mode_ser_i), .ser_data_i(ser_data_i),
    .ser_clk_i(ser_clk_i), .le_i(le_i), .par_word_i(par_word_i),
    .preset_i(preset_i), .word_o(word_o), .half_db_o(half_db_o)
  );

  function automatic int exp_half(input logic [5:0] w);
    int s = 0;
    if (w[5]) s += 32;
    if (w[4]) s += 16;
    if (w[3]) s += 8;
    if (w[2]) s += 4;
    if (w[1]) s += 2;
    if (w[0]) s += 1;
    return s;
  endfunction

  task automatic check(input string req, input logic [5:0] exp);
    checks++;
    if (word_o !== exp) begin
      errors++;
      $display("FAIL %s word actual=%0d expected=%0d", req, word_o, exp);
    end
    checks++;
    if (int'(half_db_o) != exp_half(exp) || $isunknown(half_db_o)) begin
      errors++;
      $display("FAIL R1 half_db actual=%0d expected=%0d", half_db_o, exp_half(exp));
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic m, input logic [5:0] p, input logic [1:0] pc);
    @(negedge clk);
    rst_n = 1'b0; mode_ser_i = m; par_word_i = p; preset_i = pc;
    le_i = 1'b0; ser_clk_i = 1'b0; ser_data_i = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
  endtask

  task automatic sbit(input logic b, input int hp);
    ser_data_i = b;
    cyc(hp);
    ser_clk_i = 1'b1;
    cyc(hp);
    ser_clk_i = 1'b0;
    sh = {sh[4:0], b};
  endtask

  task automatic le_pulse();
    le_i = 1'b1; cyc(3); le_i = 1'b0; cyc(5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [5:0] prev;
    // R8: presets in parallel mode
    for (int c = 0; c < 4; c++) begin
      do_reset(1'b0, 6'h2A, 2'(c));
      check("R8", (c == 0) ? 6'd0 : (c == 1) ? 6'd16 : (c == 2) ? 6'd32 : 6'd63);
    end
    // R7: reset in serial mode takes the parallel pins
    for (int v = 0; v < 64; v += 9) begin
      do_reset(1'b1, 6'(v), 2'b11);
      check("R7", 6'(v));
    end

    // R5/R9: exhaustive serial words at the fastest clock, plus a slower pass
    do_reset(1'b1, 6'd5, 2'b00);
    sh = 6'd5; prev = 6'd5;
    for (int v = 0; v < 64; v++) begin
      for (int i = 5; i >= 0; i--) sbit(v[i], 2);
      cyc(6);
      check("R5", prev);
      le_pulse();
      check("R9", 6'(v));
      prev = 6'(v);
    end
    for (int v = 7; v < 64; v += 14) begin
      for (int i = 5; i >= 0; i--) sbit(v[i], 5);
      cyc(6);
      le_pulse();
      check("R5", 6'(v));
    end

    // R6: LE held high, word tracks each shifted bit
    le_i = 1'b1; cyc(5);
    for (int k = 0; k < 12; k++) begin
      sbit(1'((k * 5) >> 1), 3);
      cyc(5);
      check("R6", sh);
    end
    // R2: parallel pins ignored in serial mode even with LE high
    prev = sh;
    par_word_i = ~sh; cyc(8);
    check("R2", prev);
    le_i = 1'b0; cyc(4);

    // R4: latched parallel mode, all 64 values
    do_reset(1'b0, 6'd0, 2'b01);
    prev = 6'd16;
    check("R8", prev);
    for (int v = 0; v < 64; v++) begin
      par_word_i = 6'(v ^ 21);
      cyc(6);
      check("R4", prev);
      le_pulse();
      par_word_i = 6'(v);
      cyc(6);
      check("R4", 6'(v ^ 21));
      prev = 6'(v ^ 21);
    end
    // R2: serial activity ignored in parallel mode
    for (int i = 0; i < 6; i++) sbit(1'b1, 2);
    cyc(6);
    check("R2", prev);
    le_i = 1'b1; cyc(5);
    check("R2", par_word_i);

    // R3: direct mode, output follows within 3 edges
    for (int v = 0; v < 64; v++) begin
      par_word_i = 6'(63 - v);
      cyc(4);
      check("R3", 6'(63 - v));
    end
    le_i = 1'b0; cyc(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule